// File: doc/BRIEF.md
# Flash Operation Arbiter with Wipe Sequencer

This block sits between two requestors and a flash protocol engine. One requestor is a software command port that issues read, program and erase commands one at a time. The other is a single hardware wipe request. The wipe cannot be cancelled. Once the block accepts it, it takes the engine and walks a configured range of pages. For each page it erases the page, programs a fixed pattern into every word, and reads every word back to check it.

A wipe that is latched while a software command is in flight lets that command finish first. From the moment the request is latched until reset, every software command is refused. A refused command completes at once with an error and never reaches the array. The wipe also waits for flash initialization to complete, so the request may come before or after the initialization start pulse. The sequencer ends in a done state, or in an invalid state that raises a fatal flag when a read-back mismatches. Both end states hold until reset.

The array is a small behavioural stub with fixed latencies. Its contents survive reset, as a flash array would. Programming can only clear bits: the stored word becomes the old word AND the written data.

Top module: `flash_op_arb`

## Requirements
- R1: While reset is held and after it is released, `sw_busy_o`, `init_done_o`, `wipe_ack_o`, `wipe_done_o` and `fatal_o` are 0 and `wipe_state_o` is 0 (idle).
- R2: `init_done_o` rises only after an `init_start_i` pulse followed by INIT_CYCLES cycles. Software commands issued before it rises are refused: `sw_done_o` and `sw_err_o` are high one cycle after the request.
- R3: The command code on `sw_op_i` is 0 for read, 1 for program and 2 for erase. The address is {page, word}, with the word index in the low bits. An erase sets every word of the addressed page to all ones and leaves other pages alone. A program stores old AND data. A read returns the stored word. Each accepted command ends with one `sw_done_o` pulse with `sw_err_o` low.
- R4: Command code 3 is refused with an error and leaves the array unchanged.
- R5: If a wipe request arrives while a software command is in flight, that command completes without error before `wipe_ack_o` is seen. No error-free software completion occurs while the wipe runs.
- R6: `wipe_ack_o` is a single-cycle pulse, given exactly once per reset, in the cycle the sequencer leaves idle.
- R7: From the cycle after the wipe request is latched until reset, every software command is refused with an error and does not touch the array.
- R8: A wipe requested before `init_start_i` stays idle, with no acknowledge, until initialization completes, and then runs.
- R9: A clean wipe ends in state 5 (done), with `wipe_done_o` high and `fatal_o` low. It stays there and ignores later wipe requests.
- R10: After a clean wipe, every word of pages WIPE_BASE to WIPE_BASE+WIPE_PAGES-1 holds WIPE_PAT. All other words are unchanged, which is visible after reset.
- R11: A read-back mismatch during the wipe sends the sequencer to state 6 (invalid), with `fatal_o` and `wipe_done_o` high, until reset. Driving `prog_flip_i` high inverts bit 0 of program data on its way to the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_start_i | input | 1 | Pulse that starts flash initialization |
| init_done_o | output | 1 | Initialization complete |
| sw_req_i | input | 1 | Software command strobe, only while `sw_busy_o` is low |
| sw_op_i | input | 2 | Command code: 0 read, 1 program, 2 erase, 3 invalid |
| sw_addr_i | input | AW | Word address {page, word} |
| sw_wdata_i | input | DW | Program data |
| sw_busy_o | output | 1 | An accepted software command is in flight |
| sw_done_o | output | 1 | Software command completion pulse |
| sw_err_o | output | 1 | Completion is a refusal |
| sw_rdata_o | output | DW | Read data, valid with `sw_done_o` on a read |
| wipe_req_i | input | 1 | Device wipe request |
| wipe_ack_o | output | 1 | Sequencer left idle |
| wipe_done_o | output | 1 | Sequencer is in a terminal state |
| wipe_state_o | output | 3 | Sequencer state: 0 idle, 1 page select, 2 erase, 3 program, 4 verify, 5 done, 6 invalid |
| fatal_o | output | 1 | Wipe hit a program-path data error |
| prog_flip_i | input | 1 | Corrupts bit 0 of program data (error injection) |

## Verification
The bench starts a long erase and raises the wipe request one cycle later. A design that failed to drain would acknowledge early, lose the erase, or report it as refused. The bench tries both orderings of the wipe request against the initialization start. A design that ignored initialization would start the wipe from idle too early.

The array keeps its contents across reset. This lets the bench read back after reset and confirm that only the configured page range holds the pattern, and that a program refused during the lock never landed. A sequencer with an off-by-one page or word limit shows up in that read-back.

Finally, a corrupted program path must end in the invalid state with the fatal flag held. A design that retried, or that reported done without the flag, fails there.

// File: rtl/flash_wipe_pkg.sv
package flash_wipe_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_BAD   = 2'd3
    } flash_op_e;

    typedef enum logic [2:0] {
        WS_IDLE     = 3'd0,
        WS_PAGE_SEL = 3'd1,
        WS_ERASE    = 3'd2,
        WS_PROG     = 3'd3,
        WS_VERIFY   = 3'd4,
        WS_DONE     = 3'd5,
        WS_INVALID  = 3'd6
    } wipe_st_e;

endpackage

// File: rtl/flash_array_stub.sv
module flash_array_stub
    import flash_wipe_pkg::*;
#(
    parameter int PAGES     = 8,
    parameter int WORDS     = 4,
    parameter int DW        = 16,
    parameter int READ_LAT  = 1,
    parameter int PROG_LAT  = 3,
    parameter int ERASE_LAT = 12
) (
    input  logic                                    clk_i,
    input  logic                                    rst_ni,
    input  logic                                    req_i,
    input  flash_op_e                               op_i,
    input  logic [$clog2(PAGES)+$clog2(WORDS)-1:0]  addr_i,
    input  logic [DW-1:0]                           wdata_i,
    output logic                                    done_o,
    output logic [DW-1:0]                           rdata_o
);
    localparam int PW    = $clog2(PAGES);
    localparam int WW    = $clog2(WORDS);
    localparam int AW    = PW + WW;
    localparam int DEPTH = PAGES * WORDS;
    localparam int ML    = (PROG_LAT > ERASE_LAT) ? PROG_LAT : ERASE_LAT;
    localparam int MAXL  = (ML > READ_LAT) ? ML : READ_LAT;
    localparam int CW    = $clog2(MAXL + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        flash_op_e     op;
        logic [AW-1:0] addr;
        logic [DW-1:0] wd;
        logic          done;
        logic [DW-1:0] rdata;
    } stub_t;

    stub_t stub_d, stub_q;
    logic [DW-1:0] mem [DEPTH];

    always_comb begin
        stub_d      = stub_q;
        stub_d.done = 1'b0;
        if (stub_q.cnt != '0) begin
            stub_d.cnt = stub_q.cnt - 1'b1;
            if (stub_q.cnt == CW'(1)) begin
                stub_d.done = 1'b1;
                if (stub_q.op == OP_READ) stub_d.rdata = mem[stub_q.addr];
            end
        end else if (req_i) begin
            stub_d.op   = op_i;
            stub_d.addr = addr_i;
            stub_d.wd   = wdata_i;
            case (op_i)
                OP_PROG:  stub_d.cnt = CW'(PROG_LAT);
                OP_ERASE: stub_d.cnt = CW'(ERASE_LAT);
                default:  stub_d.cnt = CW'(READ_LAT);
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stub_q <= '0;
        else         stub_q <= stub_d;
    end

    // array contents are not reset: they survive like a real array
    always_ff @(posedge clk_i) begin
        if (stub_q.cnt == CW'(1)) begin
            if (stub_q.op == OP_PROG) begin
                mem[stub_q.addr] <= mem[stub_q.addr] & stub_q.wd;
            end else if (stub_q.op == OP_ERASE) begin
                for (int w = 0; w < WORDS; w++) begin
                    mem[{stub_q.addr[AW-1:WW], WW'(w)}] <= '1;
                end
            end
        end
    end

    assign done_o  = stub_q.done;
    assign rdata_o = stub_q.rdata;

    // R3
    no_req_while_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i |-> (stub_q.cnt == '0));

endmodule

// File: rtl/wipe_seq.sv
module wipe_seq
    import flash_wipe_pkg::*;
#(
    parameter int              PAGES      = 8,
    parameter int              WORDS      = 4,
    parameter int              DW         = 16,
    parameter int              WIPE_BASE  = 2,
    parameter int              WIPE_PAGES = 4,
    parameter logic [DW-1:0]   WIPE_PAT   = 16'hA5C3
) (
    input  logic                                    clk_i,
    input  logic                                    rst_ni,
    input  logic                                    go_i,
    input  logic                                    fl_done_i,
    input  logic [DW-1:0]                           fl_rdata_i,
    output logic                                    fl_req_o,
    output flash_op_e                               fl_op_o,
    output logic [$clog2(PAGES)+$clog2(WORDS)-1:0]  fl_addr_o,
    output logic [DW-1:0]                           fl_wdata_o,
    output logic                                    active_o,
    output logic                                    ack_o,
    output logic                                    done_o,
    output logic                                    fatal_o,
    output wipe_st_e                                state_o
);
    localparam int PW   = $clog2(PAGES);
    localparam int WW   = $clog2(WORDS);
    localparam int LAST = WIPE_BASE + WIPE_PAGES - 1;

    typedef struct packed {
        wipe_st_e      st;
        logic [PW-1:0] page;
        logic [WW-1:0] word;
        logic          issued;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d    = seq_q;
        fl_req_o = 1'b0;
        fl_op_o  = OP_READ;
        case (seq_q.st)
            WS_IDLE: begin
                if (go_i) begin
                    seq_d.st   = WS_PAGE_SEL;
                    seq_d.page = PW'(WIPE_BASE);
                end
            end
            WS_PAGE_SEL: begin
                seq_d.word   = '0;
                seq_d.issued = 1'b0;
                seq_d.st     = WS_ERASE;
            end
            WS_ERASE: begin
                fl_op_o      = OP_ERASE;
                fl_req_o     = !seq_q.issued;
                seq_d.issued = 1'b1;
                if (fl_done_i) begin
                    seq_d.issued = 1'b0;
                    seq_d.st     = WS_PROG;
                end
            end
            WS_PROG: begin
                fl_op_o      = OP_PROG;
                fl_req_o     = !seq_q.issued;
                seq_d.issued = 1'b1;
                if (fl_done_i) begin
                    seq_d.issued = 1'b0;
                    seq_d.word   = seq_q.word + 1'b1;
                    if (seq_q.word == WW'(WORDS - 1)) begin
                        seq_d.word = '0;
                        seq_d.st   = WS_VERIFY;
                    end
                end
            end
            WS_VERIFY: begin
                fl_op_o      = OP_READ;
                fl_req_o     = !seq_q.issued;
                seq_d.issued = 1'b1;
                if (fl_done_i) begin
                    seq_d.issued = 1'b0;
                    seq_d.word   = seq_q.word + 1'b1;
                    if (fl_rdata_i != WIPE_PAT) begin
                        seq_d.st = WS_INVALID;
                    end else if (seq_q.word == WW'(WORDS - 1)) begin
                        seq_d.word = '0;
                        if (seq_q.page == PW'(LAST)) begin
                            seq_d.st = WS_DONE;
                        end else begin
                            seq_d.page = seq_q.page + 1'b1;
                            seq_d.st   = WS_PAGE_SEL;
                        end
                    end
                end
            end
            default: seq_d = seq_q;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seq_q <= '{st: WS_IDLE, page: '0, word: '0, issued: 1'b0};
        else         seq_q <= seq_d;
    end

    assign fl_addr_o  = {seq_q.page, seq_q.word};
    assign fl_wdata_o = WIPE_PAT;
    assign active_o   = (seq_q.st != WS_IDLE);
    assign ack_o      = (seq_q.st == WS_IDLE) && go_i;
    assign done_o     = (seq_q.st == WS_DONE) || (seq_q.st == WS_INVALID);
    assign fatal_o    = (seq_q.st == WS_INVALID);
    assign state_o    = seq_q.st;

    // R6
    ack_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |=> (!ack_o && active_o));

    // R9
    done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.st == WS_DONE) |=> (seq_q.st == WS_DONE));

    // R11
    invalid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fatal_o |=> (fatal_o && done_o));

endmodule

// File: rtl/flash_op_arb.sv
module flash_op_arb
    import flash_wipe_pkg::*;
#(
    parameter int              PAGES       = 8,
    parameter int              WORDS       = 4,
    parameter int              DW          = 16,
    parameter int              READ_LAT    = 1,
    parameter int              PROG_LAT    = 3,
    parameter int              ERASE_LAT   = 12,
    parameter int              INIT_CYCLES = 20,
    parameter int              WIPE_BASE   = 2,
    parameter int              WIPE_PAGES  = 4,
    parameter logic [DW-1:0]   WIPE_PAT    = 16'hA5C3,
    localparam int             AW          = $clog2(PAGES) + $clog2(WORDS)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          init_start_i,
    output logic          init_done_o,
    input  logic          sw_req_i,
    input  logic [1:0]    sw_op_i,
    input  logic [AW-1:0] sw_addr_i,
    input  logic [DW-1:0] sw_wdata_i,
    output logic          sw_busy_o,
    output logic          sw_done_o,
    output logic          sw_err_o,
    output logic [DW-1:0] sw_rdata_o,
    input  logic          wipe_req_i,
    output logic          wipe_ack_o,
    output logic          wipe_done_o,
    output logic [2:0]    wipe_state_o,
    output logic          fatal_o,
    input  logic          prog_flip_i
);
    localparam int IW = $clog2(INIT_CYCLES + 1);

    typedef struct packed {
        logic          pend;
        logic          busy;
        logic          rej;
        logic          init_run;
        logic [IW-1:0] init_cnt;
        logic          init_done;
    } arb_t;

    arb_t arb_d, arb_q;

    logic          seq_active, seq_req, seq_go;
    flash_op_e     seq_op;
    logic [AW-1:0] seq_addr;
    logic [DW-1:0] seq_wdata;
    wipe_st_e      seq_state;

    logic          fl_req, fl_done;
    flash_op_e     fl_op;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_wdata, fl_rdata;

    logic lock, accept;

    always_comb begin
        arb_d  = arb_q;
        lock   = arb_q.pend || seq_active;
        accept = sw_req_i && !lock && arb_q.init_done && (sw_op_i != OP_BAD);

        arb_d.rej = sw_req_i && !accept;
        if (accept)                arb_d.busy = 1'b1;
        if (arb_q.busy && fl_done) arb_d.busy = 1'b0;
        if (wipe_req_i)            arb_d.pend = 1'b1;

        if (init_start_i && !arb_q.init_run && !arb_q.init_done) begin
            arb_d.init_run = 1'b1;
            arb_d.init_cnt = IW'(INIT_CYCLES);
        end else if (arb_q.init_run) begin
            arb_d.init_cnt = arb_q.init_cnt - 1'b1;
            if (arb_q.init_cnt == IW'(1)) begin
                arb_d.init_run  = 1'b0;
                arb_d.init_done = 1'b1;
            end
        end

        seq_go = arb_q.pend && !arb_q.busy && arb_q.init_done;

        if (seq_active) begin
            fl_req   = seq_req;
            fl_op    = seq_op;
            fl_addr  = seq_addr;
            fl_wdata = seq_wdata;
        end else begin
            fl_req   = accept;
            fl_op    = flash_op_e'(sw_op_i);
            fl_addr  = sw_addr_i;
            fl_wdata = sw_wdata_i;
        end
        fl_wdata[0] = fl_wdata[0] ^ prog_flip_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) arb_q <= '0;
        else         arb_q <= arb_d;
    end

    wipe_seq #(
        .PAGES(PAGES), .WORDS(WORDS), .DW(DW),
        .WIPE_BASE(WIPE_BASE), .WIPE_PAGES(WIPE_PAGES), .WIPE_PAT(WIPE_PAT)
    ) u_seq (
        .clk_i(clk_i), .rst_ni(rst_ni), .go_i(seq_go),
        .fl_done_i(fl_done), .fl_rdata_i(fl_rdata),
        .fl_req_o(seq_req), .fl_op_o(seq_op), .fl_addr_o(seq_addr), .fl_wdata_o(seq_wdata),
        .active_o(seq_active), .ack_o(wipe_ack_o), .done_o(wipe_done_o),
        .fatal_o(fatal_o), .state_o(seq_state)
    );

    flash_array_stub #(
        .PAGES(PAGES), .WORDS(WORDS), .DW(DW),
        .READ_LAT(READ_LAT), .PROG_LAT(PROG_LAT), .ERASE_LAT(ERASE_LAT)
    ) u_array (
        .clk_i(clk_i), .rst_ni(rst_ni), .req_i(fl_req), .op_i(fl_op),
        .addr_i(fl_addr), .wdata_i(fl_wdata), .done_o(fl_done), .rdata_o(fl_rdata)
    );

    assign init_done_o  = arb_q.init_done;
    assign sw_busy_o    = arb_q.busy;
    assign sw_done_o    = arb_q.rej || (arb_q.busy && fl_done);
    assign sw_err_o     = arb_q.rej;
    assign sw_rdata_o   = fl_rdata;
    assign wipe_state_o = seq_state;

    // R5
    no_sw_finish_in_wipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sw_done_o && !sw_err_o) |-> !seq_active);

    // R7
    locked_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sw_req_i && lock) |=> (sw_done_o && sw_err_o));

    // R2
    early_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sw_req_i && !init_done_o) |=> (sw_done_o && sw_err_o));

endmodule

// File: tb/flash_op_arb_bench.sv
`timescale 1ns/1ps
module flash_op_arb_bench;
    import flash_wipe_pkg::*;

    localparam int             NW   = 32;
    localparam logic [15:0]    PAT  = 16'hA5C3;
    localparam int             BASE = 2;
    localparam int             NP   = 4;

    logic        clk = 1'b0;
    logic        rst_n, init_start, sw_req, wipe_req, prog_flip;
    logic [1:0]  sw_op;
    logic [4:0]  sw_addr;
    logic [15:0] sw_wdata, sw_rdata;
    logic        init_done, sw_busy, sw_done, sw_err, wipe_ack, wipe_done, fatal;
    logic [2:0]  wipe_state;

    int total = 0;
    int bad   = 0;
    int ack_cnt = 0;
    logic [15:0] exp_mem [NW];

    always #2.5 clk = ~clk;

    flash_op_arb #(
        .PAGES(8), .WORDS(4), .DW(16), .READ_LAT(1), .PROG_LAT(3), .ERASE_LAT(12),
        .INIT_CYCLES(20), .WIPE_BASE(BASE), .WIPE_PAGES(NP), .WIPE_PAT(PAT)
    ) u_flash_op_arb (
        .clk_i(clk), .rst_ni(rst_n), .init_start_i(init_start), .init_done_o(init_done),
        .sw_req_i(sw_req), .sw_op_i(sw_op), .sw_addr_i(sw_addr), .sw_wdata_i(sw_wdata),
        .sw_busy_o(sw_busy), .sw_done_o(sw_done), .sw_err_o(sw_err), .sw_rdata_o(sw_rdata),
        .wipe_req_i(wipe_req), .wipe_ack_o(wipe_ack), .wipe_done_o(wipe_done),
        .wipe_state_o(wipe_state), .fatal_o(fatal), .prog_flip_i(prog_flip)
    );

    always @(negedge clk) if (rst_n && wipe_ack) ack_cnt++;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sw_cmd(input logic [1:0] op, input logic [4:0] addr, input logic [15:0] wd,
                          output logic err, output logic [15:0] rd);
        int n = 0;
        @(negedge clk);
        sw_req = 1'b1; sw_op = op; sw_addr = addr; sw_wdata = wd;
        @(negedge clk);
        sw_req = 1'b0;
        while (!sw_done && n < 200) begin
            @(negedge clk);
            n++;
        end
        err = sw_done ? sw_err : 1'b1;
        rd  = sw_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ack_cnt = 0;
    endtask

    task automatic do_init();
        int n = 0;
        @(negedge clk); init_start = 1'b1;
        @(negedge clk); init_start = 1'b0;
        while (!init_done && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_wipe();
        int n = 0;
        while (!wipe_done && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic pulse_wipe();
        @(negedge clk); wipe_req = 1'b1;
        @(negedge clk); wipe_req = 1'b0;
    endtask

    task automatic read_all(input string req);
        logic e;
        logic [15:0] r;
        for (int a = 0; a < NW; a++) begin
            sw_cmd(OP_READ, 5'(a), 16'h0, e, r);
            chk(!e && r == exp_mem[a], req, {15'(a), e, r}, {16'(a), exp_mem[a]});
        end
    endtask

    initial begin
        #(5.0 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic e;
        logic [15:0] r;
        int n;
        init_start = 0; sw_req = 0; wipe_req = 0; prog_flip = 0;
        sw_op = 0; sw_addr = 0; sw_wdata = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk({sw_busy, init_done, wipe_ack, wipe_done, fatal, wipe_state} == 8'h0,
            "R1 reset", {sw_busy, init_done, wipe_ack, wipe_done, fatal, wipe_state}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({sw_busy, init_done, wipe_done, fatal, wipe_state} == 7'h0,
            "R1 after release", {sw_busy, init_done, wipe_done, fatal, wipe_state}, 0);

        // R2 refused before init
        sw_cmd(OP_READ, 5'd3, 16'h0, e, r);
        chk(e == 1'b1, "R2 early refuse", e, 1);
        @(negedge clk); init_start = 1'b1;
        @(negedge clk); init_start = 1'b0;
        repeat (5) @(negedge clk);
        chk(init_done == 1'b0, "R2 init not early", init_done, 0);
        n = 0;
        while (!init_done && n < 200) begin @(negedge clk); n++; end
        chk(init_done == 1'b1 && n >= 10, "R2 init done", {init_done, 16'(n)}, 1);

        // R3 erase everything, two program passes, partial erase
        for (int p = 0; p < 8; p++) begin
            sw_cmd(OP_ERASE, 5'(p * 4), 16'h0, e, r);
            chk(!e, "R3 erase ok", e, 0);
        end
        for (int a = 0; a < NW; a++) exp_mem[a] = 16'hFFFF;
        for (int a = 0; a < NW; a++) begin
            logic [15:0] v = 16'(a * 16'h1357) ^ 16'h0F0F;
            sw_cmd(OP_PROG, 5'(a), v, e, r);
            exp_mem[a] = exp_mem[a] & v;
        end
        read_all("R3 first program");
        for (int a = 0; a < NW; a++) begin
            logic [15:0] v = ~(16'(a) << 3);
            sw_cmd(OP_PROG, 5'(a), v, e, r);
            exp_mem[a] = exp_mem[a] & v;
        end
        read_all("R3 second program AND");
        sw_cmd(OP_ERASE, 5'd21, 16'h0, e, r);
        for (int w = 0; w < 4; w++) exp_mem[20 + w] = 16'hFFFF;
        read_all("R3 page erase");

        // R4 invalid opcode
        sw_cmd(2'd3, 5'd7, 16'h0000, e, r);
        chk(e == 1'b1, "R4 invalid refused", e, 1);
        sw_cmd(OP_READ, 5'd7, 16'h0, e, r);
        chk(!e && r == exp_mem[7], "R4 array unchanged", r, exp_mem[7]);

        // R5 wipe during an in-flight erase of page 6
        @(negedge clk);
        sw_req = 1'b1; sw_op = OP_ERASE; sw_addr = 5'd24;
        @(negedge clk);
        sw_req = 1'b0; wipe_req = 1'b1;
        @(negedge clk);
        wipe_req = 1'b0;
        n = 0;
        while (!sw_done && n < 200) begin
            chk(wipe_ack == 1'b0, "R5 no ack before drain", wipe_ack, 0);
            @(negedge clk); n++;
        end
        chk(sw_done && !sw_err && ack_cnt == 0, "R5 erase drained", {sw_done, sw_err, 8'(ack_cnt)}, 12'h200);
        for (int w = 0; w < 4; w++) exp_mem[24 + w] = 16'hFFFF;

        // R7 refused during lock (program and read)
        sw_cmd(OP_PROG, 5'd1, 16'h0000, e, r);
        chk(e == 1'b1, "R7 prog refused", e, 1);
        sw_cmd(OP_READ, 5'd1, 16'h0, e, r);
        chk(e == 1'b1, "R7 read refused", e, 1);

        wait_wipe();
        // R6 / R9
        chk(ack_cnt == 1, "R6 one ack", ack_cnt, 1);
        chk(wipe_done && !fatal && wipe_state == 3'd5, "R9 clean end",
            {wipe_done, fatal, wipe_state}, {1'b1, 1'b0, 3'd5});
        pulse_wipe();
        repeat (20) @(negedge clk);
        chk(ack_cnt == 1 && wipe_state == 3'd5, "R9 absorbs request", {8'(ack_cnt), wipe_state}, {8'd1, 3'd5});
        for (int a = BASE * 4; a < (BASE + NP) * 4; a++) exp_mem[a] = PAT;

        // R10 contents after reset
        do_reset();
        chk(wipe_state == 3'd0 && !wipe_done, "R1 state after reset", wipe_state, 0);
        do_init();
        read_all("R10 wipe contents");

        // R8 wipe requested before init start
        do_reset();
        pulse_wipe();
        repeat (40) @(negedge clk);
        chk(ack_cnt == 0 && wipe_state == 3'd0, "R8 waits for init", {8'(ack_cnt), wipe_state}, 0);
        sw_cmd(OP_READ, 5'd0, 16'h0, e, r);
        chk(e == 1'b1, "R7 refused while pending", e, 1);
        do_init();
        wait_wipe();
        chk(ack_cnt == 1 && wipe_state == 3'd5, "R8 runs after init", {8'(ack_cnt), wipe_state}, {8'd1, 3'd5});

        // R11 corrupted program path
        do_reset();
        do_init();
        prog_flip = 1'b1;
        pulse_wipe();
        wait_wipe();
        chk(wipe_state == 3'd6 && fatal && wipe_done, "R11 invalid",
            {wipe_state, fatal, wipe_done}, {3'd6, 1'b1, 1'b1});
        repeat (10) @(negedge clk);
        chk(wipe_state == 3'd6 && fatal, "R11 held", {wipe_state, fatal}, {3'd6, 1'b1});
        prog_flip = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule